// File: doc/BRIEF.md
# MMU Fault Status Capture Unit

This unit sits behind the page-table walker of a memory management unit. Every cycle in which a translation result is presented, it looks at the error class and walk level the walker reports. On a failed translation it records a packed status word and the full faulting virtual address in two software-visible registers. It then decides whether the processor must take a trap or whether the access goes ahead anyway.

An access goes ahead anyway when the no-fault control bit is set or when traps are disabled. In that case the unit grants read/write access to the faulting page instead of trapping. It also says whether a real mapping exists, which is true when only the permission check failed. When a new fault arrives before software has read the previous status, the unit marks an overflow. Reading the status register clears it.

All outputs are registered. The result of a translation presented before a clock edge is visible right after that edge.

Top module: `fsc_unit`

## Requirements
- R1: After a synchronous active-low reset, `fault_stat` and `fault_addr` are zero, and `trap_req` and `nf_grant` are low.
- R2: A fault is a cycle with `xlat_vld` high and `xlat_ftype` nonzero. If `fault_stat` is zero and no read occurs in that cycle, the status after the edge is `{lvl[9:8], acc[7:5], ftype[4:2], 1'b1 at bit 1, 1'b0 at bit 0}`. Bit 1 means the fault address is valid.
- R3: A fault arriving while `fault_stat` is nonzero and not being read discards the old fields. It stores the new fields from R2 and sets bit 0 (overflow).
- R4: On every fault, `fault_addr` is loaded with the full `xlat_va`.
- R5: A cycle without a fault (`xlat_vld` low, or `xlat_ftype` zero) leaves `fault_addr` unchanged. It also leaves `fault_stat` unchanged unless it is being read. It raises neither `trap_req` nor `nf_grant`.
- R6: With `stat_rd` high, `fault_stat` shows the current value during that cycle and is zero after the edge. `fault_addr` is not affected by the read.
- R7: When `stat_rd` and a fault fall in the same cycle, the read sees the old value. The status after the edge holds only the new fault, with bit 0 clear.
- R8: A fault with `nofault_en` low and `traps_en` high raises `trap_req` after the edge. `trap_type` is `TT_INSN` (default 8'h01) when `is_fetch` is high and `TT_DATA` (default 8'h09) otherwise.
- R9: A fault with `nofault_en` high or `traps_en` low raises `nf_grant` instead of `trap_req`. The two are never high together.
- R10: With `nf_grant`, `nf_mapped` is high exactly when `xlat_ftype` is a permission error (code 2 or 3). It is low for walk errors (code 1 invalid, 4 reserved).
- R11: `trap_req` and `nf_grant` are single-cycle pulses, one per fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xlat_vld | input | 1 | A translation result is presented this cycle |
| xlat_acc | input | 3 | Access index (user/supervisor, data/fetch, read/write) |
| xlat_lvl | input | 2 | Walk level at which the error occurred |
| xlat_ftype | input | 3 | Error class, 0 = translation succeeded |
| xlat_va | input | 32 | Virtual address of the access |
| is_fetch | input | 1 | Access is an instruction fetch |
| nofault_en | input | 1 | No-fault control bit |
| traps_en | input | 1 | Processor trap enable |
| stat_rd | input | 1 | Software read strobe for the status register |
| fault_stat | output | 10 | Fault status register |
| fault_addr | output | 32 | Fault address register |
| trap_req | output | 1 | Trap request pulse |
| trap_type | output | 8 | Trap type for the request |
| nf_grant | output | 1 | Access granted read/write in place of a trap |
| nf_mapped | output | 1 | Granted access has a valid mapping |

## Verification
Two functions of this block can fall in the same cycle: a software status read and the capture of a new fault. The bench first leaves a nonzero status in place. It then raises `stat_rd` together with a faulting translation. It checks that the value seen during the read is the old word. It also checks that the word after the edge is exactly the new fault with the overflow bit clear, which shows the read emptied the register before the capture. A second sequence leaves the status unread across two faults, so that the overflow path is taken.

// File: rtl/fsc_pkg.sv
// Package: shared widths, status-field positions and helpers for the
// fault status capture unit. Assumes status fields are packed from bit 0
// upward in the order overflow, address-valid, type, access, level.
package fsc_pkg;

    localparam int LVL_W = 2;
    localparam int FT_W  = 3;
    localparam int ACC_W = 3;

    localparam int OVF_BIT = 0;
    localparam int FAV_BIT = 1;
    localparam int FT_LSB  = 2;
    localparam int ACC_LSB = FT_LSB + FT_W;
    localparam int LVL_LSB = ACC_LSB + ACC_W;
    localparam int STAT_W  = LVL_LSB + LVL_W;

    // Error class codes reported by the walker
    localparam logic [FT_W-1:0] FT_NONE  = 3'd0;
    localparam logic [FT_W-1:0] FT_PERMA = 3'd2;
    localparam logic [FT_W-1:0] FT_PERMB = 3'd3;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [ACC_W-1:0] acc;
        logic [FT_W-1:0]  ftype;
    } fault_info_t;

    // Builds the status word for a fresh fault (overflow bit clear)
    function automatic logic [STAT_W-1:0] pack_status(fault_info_t f);
        logic [STAT_W-1:0] w;
        w = '0;
        w[LVL_LSB +: LVL_W] = f.lvl;
        w[ACC_LSB +: ACC_W] = f.acc;
        w[FT_LSB  +: FT_W]  = f.ftype;
        w[FAV_BIT]          = 1'b1;
        return w;
    endfunction

    // True when the error class is a permission failure on a valid mapping
    function automatic logic is_perm_err(logic [FT_W-1:0] ft);
        return (ft == FT_PERMA) || (ft == FT_PERMB);
    endfunction

endpackage

// File: rtl/fsc_status_reg.sv
// Fault status register. Captures the packed status on a fault, marks an
// overflow when the previous value was still unread, and clears on a
// software read. Assumes a read and a fault in the same cycle mean the
// read consumed the old value, so the capture starts from zero.
module fsc_status_reg
    import fsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_now,
    input  fault_info_t       info,
    input  logic              rd_stb,
    output logic [STAT_W-1:0] stat_q
);

    logic [STAT_W-1:0] fresh;
    logic              prior_unread;

    // Status word for the incoming fault and the overflow condition
    always_comb begin
        fresh        = pack_status(info);
        prior_unread = (stat_q != '0) && !rd_stb;
        if (prior_unread) begin
            fresh[OVF_BIT] = 1'b1;
        end
    end

    // Capture on fault, clear on read, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (fault_now) begin
            stat_q <= fresh;
        end else if (rd_stb) begin
            stat_q <= '0;
        end
    end

endmodule

// File: rtl/fsc_addr_reg.sv
// Fault address register. Loads the full virtual address of every fault.
// Assumes reads have no side effect on this register.
module fsc_addr_reg #(
    parameter int VA_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fault_now,
    input  logic [VA_W-1:0] va,
    output logic [VA_W-1:0] addr_q
);

    // Load on fault, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (fault_now) begin
            addr_q <= va;
        end
    end

endmodule

// File: rtl/fsc_decide.sv
// Trap / no-fault decision. For each fault it emits a single-cycle trap
// request with a type chosen by the fetch flag. When no-fault mode is on
// or traps are off, it emits an override grant instead. Assumes the
// decision inputs are valid in the same cycle as the fault.
module fsc_decide
    import fsc_pkg::*;
#(
    parameter int              TT_W    = 8,
    parameter logic [TT_W-1:0] TT_INSN = 8'h01,
    parameter logic [TT_W-1:0] TT_DATA = 8'h09
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fault_now,
    input  logic [FT_W-1:0] ftype,
    input  logic            fetch,
    input  logic            nofault,
    input  logic            traps_on,
    output logic            trap_q,
    output logic [TT_W-1:0] tt_q,
    output logic            grant_q,
    output logic            mapped_q
);

    logic suppress;

    // A trap is suppressed in no-fault mode or with traps disabled
    always_comb suppress = nofault || !traps_on;

    // Register the decision as single-cycle pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_q   <= 1'b0;
            tt_q     <= '0;
            grant_q  <= 1'b0;
            mapped_q <= 1'b0;
        end else begin
            trap_q   <= fault_now && !suppress;
            grant_q  <= fault_now && suppress;
            mapped_q <= fault_now && suppress && is_perm_err(ftype);
            if (fault_now && !suppress) begin
                tt_q <= fetch ? TT_INSN : TT_DATA;
            end
        end
    end

endmodule

// File: rtl/fsc_unit.sv
// Top of the fault status capture unit. Qualifies the translation result
// as a fault and feeds the status register, the address register and the
// trap decision. Assumes one translation result per cycle at most.
module fsc_unit
    import fsc_pkg::*;
#(
    parameter int              VA_W    = 32,
    parameter int              TT_W    = 8,
    parameter logic [TT_W-1:0] TT_INSN = 8'h01,
    parameter logic [TT_W-1:0] TT_DATA = 8'h09
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlat_vld,
    input  logic [ACC_W-1:0]  xlat_acc,
    input  logic [LVL_W-1:0]  xlat_lvl,
    input  logic [FT_W-1:0]   xlat_ftype,
    input  logic [VA_W-1:0]   xlat_va,
    input  logic              is_fetch,
    input  logic              nofault_en,
    input  logic              traps_en,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] fault_stat,
    output logic [VA_W-1:0]   fault_addr,
    output logic              trap_req,
    output logic [TT_W-1:0]   trap_type,
    output logic              nf_grant,
    output logic              nf_mapped
);

    logic        fault_now;
    fault_info_t info;

    // A presented result with a nonzero error class is a fault
    always_comb begin
        fault_now  = xlat_vld && (xlat_ftype != FT_NONE);
        info.lvl   = xlat_lvl;
        info.acc   = xlat_acc;
        info.ftype = xlat_ftype;
    end

    fsc_status_reg u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_now (fault_now),
        .info      (info),
        .rd_stb    (stat_rd),
        .stat_q    (fault_stat)
    );

    fsc_addr_reg #(.VA_W(VA_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_now (fault_now),
        .va        (xlat_va),
        .addr_q    (fault_addr)
    );

    fsc_decide #(.TT_W(TT_W), .TT_INSN(TT_INSN), .TT_DATA(TT_DATA)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_now (fault_now),
        .ftype     (xlat_ftype),
        .fetch     (is_fetch),
        .nofault   (nofault_en),
        .traps_on  (traps_en),
        .trap_q    (trap_req),
        .tt_q      (trap_type),
        .grant_q   (nf_grant),
        .mapped_q  (nf_mapped)
    );

endmodule

// File: rtl/fsc_checker.sv
// Checker for fsc_unit: relates the port-level inputs of one cycle to the
// registered outputs of the next. Attached with bind below.
module fsc_checker
    import fsc_pkg::*;
#(
    parameter int VA_W = 32,
    parameter int TT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xlat_vld,
    input logic [FT_W-1:0]   xlat_ftype,
    input logic [VA_W-1:0]   xlat_va,
    input logic              nofault_en,
    input logic              traps_en,
    input logic              stat_rd,
    input logic [STAT_W-1:0] fault_stat,
    input logic [VA_W-1:0]   fault_addr,
    input logic              trap_req,
    input logic              nf_grant
);

    logic flt;
    always_comb flt = xlat_vld && (xlat_ftype != 3'd0);

    p_fav_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flt |=> fault_stat[FAV_BIT]);

    p_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flt && !stat_rd && fault_stat != '0) |=> fault_stat[OVF_BIT]);

    p_far_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flt |=> (fault_addr == $past(xlat_va)));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flt && !stat_rd) |=> ($stable(fault_stat) && $stable(fault_addr)));

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flt && stat_rd) |=> (fault_stat == '0));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flt && (stat_rd || fault_stat == '0)) |=> !fault_stat[OVF_BIT]);

    p_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flt && !nofault_en && traps_en) |=> trap_req);

    p_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flt && (nofault_en || !traps_en)) |=> (nf_grant && !trap_req));

    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !flt |=> (!trap_req && !nf_grant));

endmodule

bind fsc_unit fsc_checker #(.VA_W(VA_W), .TT_W(TT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xlat_vld   (xlat_vld),
    .xlat_ftype (xlat_ftype),
    .xlat_va    (xlat_va),
    .nofault_en (nofault_en),
    .traps_en   (traps_en),
    .stat_rd    (stat_rd),
    .fault_stat (fault_stat),
    .fault_addr (fault_addr),
    .trap_req   (trap_req),
    .nf_grant   (nf_grant)
);

// File: tb/sim_fsc_unit.sv
// Directed bench for fsc_unit: one task per scenario, each checking its
// own results against values computed from the requirements.
module sim_fsc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlat_vld = 1'b0;
    logic [2:0]  xlat_acc = '0;
    logic [1:0]  xlat_lvl = '0;
    logic [2:0]  xlat_ftype = '0;
    logic [31:0] xlat_va = '0;
    logic        is_fetch = 1'b0;
    logic        nofault_en = 1'b0;
    logic        traps_en = 1'b1;
    logic        stat_rd = 1'b0;
    logic [9:0]  fault_stat;
    logic [31:0] fault_addr;
    logic        trap_req;
    logic [7:0]  trap_type;
    logic        nf_grant;
    logic        nf_mapped;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    fsc_unit u0 (
        .clk(clk), .rst_n(rst_n), .xlat_vld(xlat_vld), .xlat_acc(xlat_acc),
        .xlat_lvl(xlat_lvl), .xlat_ftype(xlat_ftype), .xlat_va(xlat_va),
        .is_fetch(is_fetch), .nofault_en(nofault_en), .traps_en(traps_en),
        .stat_rd(stat_rd), .fault_stat(fault_stat), .fault_addr(fault_addr),
        .trap_req(trap_req), .trap_type(trap_type), .nf_grant(nf_grant),
        .nf_mapped(nf_mapped)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [9:0] stat_word(input logic [1:0] l, input logic [2:0] a,
                                             input logic [2:0] f, input logic ovf);
        return {l, a, f, 1'b1, ovf};
    endfunction

    // Drive one translation at a negedge, let it pass one edge, sample after
    task automatic present(input logic [1:0] l, input logic [2:0] a, input logic [2:0] f,
                           input logic [31:0] va, input logic fetch,
                           input logic nf, input logic ten, input logic rd);
        @(negedge clk);
        xlat_vld = 1'b1; xlat_lvl = l; xlat_acc = a; xlat_ftype = f;
        xlat_va = va; is_fetch = fetch; nofault_en = nf; traps_en = ten; stat_rd = rd;
        @(posedge clk); #1;
        xlat_vld = 1'b0; stat_rd = 1'b0; xlat_ftype = '0;
    endtask

    task automatic t_reset;
        chk("R1", "stat", 32'(fault_stat), 32'h0);
        chk("R1", "addr", fault_addr, 32'h0);
        chk("R1", "trap", 32'(trap_req), 32'h0);
        chk("R1", "grant", 32'(nf_grant), 32'h0);
    endtask

    task automatic t_first_fault;
        present(2'd2, 3'd3, 3'd1, 32'h1234_5678, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R2", "stat", 32'(fault_stat), 32'(stat_word(2'd2, 3'd3, 3'd1, 1'b0)));
        chk("R4", "addr", fault_addr, 32'h1234_5678);
        chk("R8", "trap", 32'(trap_req), 32'h1);
        chk("R8", "type data", 32'(trap_type), 32'h09);
        chk("R9", "no grant", 32'(nf_grant), 32'h0);
        @(posedge clk); #1;
        chk("R11", "trap pulse", 32'(trap_req), 32'h0);
    endtask

    task automatic t_overflow;
        present(2'd1, 3'd6, 3'd4, 32'hDEAD_BEEF, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R3", "stat", 32'(fault_stat), 32'(stat_word(2'd1, 3'd6, 3'd4, 1'b1)));
        chk("R4", "addr", fault_addr, 32'hDEAD_BEEF);
        chk("R8", "type insn", 32'(trap_type), 32'h01);
    endtask

    task automatic t_read_clear;
        @(negedge clk);
        stat_rd = 1'b1;
        chk("R6", "value during read", 32'(fault_stat), 32'(stat_word(2'd1, 3'd6, 3'd4, 1'b1)));
        @(posedge clk); #1;
        stat_rd = 1'b0;
        chk("R6", "cleared", 32'(fault_stat), 32'h0);
        chk("R6", "addr kept", fault_addr, 32'hDEAD_BEEF);
    endtask

    task automatic t_success;
        present(2'd3, 3'd2, 3'd0, 32'h0BAD_0000, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R5", "stat", 32'(fault_stat), 32'h0);
        chk("R5", "addr", fault_addr, 32'hDEAD_BEEF);
        chk("R5", "trap", 32'(trap_req), 32'h0);
        chk("R5", "grant", 32'(nf_grant), 32'h0);
    endtask

    task automatic t_nofault_perm;
        present(2'd3, 3'd1, 3'd2, 32'hCAFE_0123, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R2", "stat nf", 32'(fault_stat), 32'(stat_word(2'd3, 3'd1, 3'd2, 1'b0)));
        chk("R9", "no trap", 32'(trap_req), 32'h0);
        chk("R9", "grant", 32'(nf_grant), 32'h1);
        chk("R10", "mapped", 32'(nf_mapped), 32'h1);
        @(posedge clk); #1;
        chk("R11", "grant pulse", 32'(nf_grant), 32'h0);
    endtask

    task automatic t_read_collide_traps_off;
        @(negedge clk);
        chk("R7", "old before read", 32'(fault_stat), 32'(stat_word(2'd3, 3'd1, 3'd2, 1'b0)));
        present(2'd0, 3'd0, 3'd1, 32'h0000_F00D, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R7", "fresh no overflow", 32'(fault_stat), 32'(stat_word(2'd0, 3'd0, 3'd1, 1'b0)));
        chk("R9", "traps off no trap", 32'(trap_req), 32'h0);
        chk("R9", "traps off grant", 32'(nf_grant), 32'h1);
        chk("R10", "walk error unmapped", 32'(nf_mapped), 32'h0);
        chk("R4", "addr", fault_addr, 32'h0000_F00D);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_first_fault();
        t_overflow();
        t_read_clear();
        t_success();
        t_nofault_perm();
        t_read_collide_traps_off();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule